// File: doc/BRIEF.md
# Light Sensor Measurement Cycle Sequencer

This block is the free-running timing engine of a color light sensor. Once powered and enabled, it steps through a fixed one-step initialization slot and a programmable integration window. It can then insert an optional programmable low-power pause before it starts the next conversion. It repeats this loop without any external trigger for as long as conversion stays enabled.

The integration length and the wait length each come from an 8-bit setting `x` and equal `(256 - x)` steps. A prescaler makes the step tick from the system clock, and its divide ratio is a parameter. A long-wait bit makes each wait step twelve times as long and leaves the integration step as it is.

The lengths and the long-wait bit are sampled when a phase begins. A write made while a phase is running therefore applies from the next phase. Removing power forces the idle state on the next clock. Removing conversion enable lets the current integration run to its end and then stops the loop.

Top module: `light_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released, `phase` is 0 (idle), and `integrating`, `conv_done` and `low_power` are 0 until both `pwr_on` and `conv_en` are set.
- R2: With `pwr_on` and `conv_en` high in idle, the sequencer enters the init phase (`phase`=1) on the next clock. Init lasts exactly one step (`TICK_DIV` clocks) and is followed by integration.
- R3: The integration phase (`phase`=2) lasts `(256 - int_cfg)` steps. The value 0xFF gives 1 step and 0x00 gives 256 steps.
- R4: `conv_done` is high for exactly one clock, in the first clock after an integration phase ends.
- R5: With `wait_en` low, integration is followed directly by init, so conversions run back to back with no wait phase.
- R6: With `wait_en` high and `long_wait` low, integration is followed by a wait phase (`phase`=3) of `(256 - wait_cfg)` steps, and then by init. `low_power` is high only in the wait phase.
- R7: With `long_wait` high, each wait step is 12 steps long, while an integration step keeps its normal length.
- R8: `int_cfg`, `wait_cfg` and `long_wait` are sampled when their phase starts. A change made during a phase does not alter that phase and applies from the next one.
- R9: When `pwr_on` is low, `phase` is 0 on the next clock, whatever the state. No `conv_done` is produced in that case.
- R10: When `conv_en` is cleared during integration, that integration runs to full length and still produces `conv_done`. The sequencer then returns to idle and stays there.
- R11: `phase` encodes idle=0, init=1, integration=2, wait=3. `integrating` is high exactly while `phase` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Power-on enable |
| conv_en | input | 1 | Conversion loop enable |
| wait_en | input | 1 | Insert wait phase between conversions |
| long_wait | input | 1 | Multiply wait step by 12 |
| int_cfg | input | 8 | Integration setting, length = 256 - value steps |
| wait_cfg | input | 8 | Wait setting, length = 256 - value steps |
| phase | output | 2 | Current phase: 0 idle, 1 init, 2 integrate, 3 wait |
| integrating | output | 1 | High during the integration phase |
| conv_done | output | 1 | One-clock pulse after each integration |
| low_power | output | 1 | High during the wait phase |

## Verification
The bound checker watches, on every clock, the properties that hold from one clock to the next:
- power removal forces idle on the next clock;
- `conv_done` is a single clock wide and always follows integration;
- idle can only leave toward init;
- a wait phase starts only from integration, and only with `wait_en` set;
- `low_power` and `integrating` never overlap.

The exact phase lengths in steps can only be shown by the bench's scenarios. So can the twelve-fold long-wait step, the phase-start sampling of the settings, and the orderly stop after conversion enable is cleared. The bench measures each of these by counting clocks per phase.

// File: rtl/light_cycle_seq.sv
module light_cycle_seq #(
  parameter int TICK_DIV  = 240000,
  parameter int LONG_MULT = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic       conv_en,
  input  logic       wait_en,
  input  logic       long_wait,
  input  logic [7:0] int_cfg,
  input  logic [7:0] wait_cfg,
  output logic [1:0] phase,
  output logic       integrating,
  output logic       conv_done,
  output logic       low_power
);
  localparam int PW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = $clog2(256 * LONG_MULT + 1);

  localparam logic [1:0] S_IDLE = 2'd0, S_INIT = 2'd1, S_INTEG = 2'd2, S_WAIT = 2'd3;

  logic [1:0]       state;
  logic [PW-1:0]    pres;
  logic [CNT_W-1:0] remain;
  logic             tick;
  logic [CNT_W-1:0] integ_len, wait_base, wait_len;

  assign tick      = (pres == PW'(TICK_DIV - 1));
  assign integ_len = CNT_W'(9'd256 - {1'b0, int_cfg});
  assign wait_base = CNT_W'(9'd256 - {1'b0, wait_cfg});
  assign wait_len  = long_wait ? CNT_W'(wait_base * CNT_W'(LONG_MULT)) : wait_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pres      <= '0;
      remain    <= '0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (!pwr_on) begin
        state <= S_IDLE;
        pres  <= '0;
      end else if (state == S_IDLE) begin
        if (conv_en) begin
          state  <= S_INIT;
          pres   <= '0;
          remain <= CNT_W'(1);
        end
      end else if (!tick) begin
        pres <= pres + 1'b1;
      end else begin
        pres <= '0;
        if (remain != CNT_W'(1)) begin
          remain <= remain - 1'b1;
        end else begin
          case (state)
            S_INIT: begin
              state  <= S_INTEG;
              remain <= integ_len;
            end
            S_INTEG: begin
              conv_done <= 1'b1;
              if (!conv_en) begin
                state <= S_IDLE;
              end else if (wait_en) begin
                state  <= S_WAIT;
                remain <= wait_len;
              end else begin
                state  <= S_INIT;
                remain <= CNT_W'(1);
              end
            end
            S_WAIT: begin
              if (conv_en) begin
                state  <= S_INIT;
                remain <= CNT_W'(1);
              end else begin
                state <= S_IDLE;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign phase       = state;
  assign integrating = (state == S_INTEG);
  assign low_power   = (state == S_WAIT);
endmodule

// File: rtl/light_cycle_seq_chk.sv
module light_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       wait_en,
  input logic [1:0] phase,
  input logic       integrating,
  input logic       conv_done,
  input logic       low_power
);
  assert_pwroff_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (phase == 2'd0));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  assert_done_after_integ_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(integrating));

  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |=> (phase == 2'd0 || phase == 2'd1));

  assert_wait_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_power) |-> ($past(wait_en) && $past(integrating)));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_power && integrating));
endmodule

bind light_cycle_seq light_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .wait_en(wait_en),
  .phase(phase), .integrating(integrating), .conv_done(conv_done),
  .low_power(low_power)
);

// File: tb/light_cycle_seq_test.sv
module light_cycle_seq_test;
  localparam int D = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_on = 0, conv_en = 0, wait_en = 0, long_wait = 0;
  logic [7:0] int_cfg = 8'hFF, wait_cfg = 8'hFF;
  logic [1:0] phase;
  logic integrating, conv_done, low_power;

  int checks = 0, fails = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  light_cycle_seq #(.TICK_DIV(D), .LONG_MULT(12)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .conv_en(conv_en),
    .wait_en(wait_en), .long_wait(long_wait), .int_cfg(int_cfg),
    .wait_cfg(wait_cfg), .phase(phase), .integrating(integrating),
    .conv_done(conv_done), .low_power(low_power)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(input logic [1:0] s);
    for (int i = 0; i < 20000 && phase != s; i++) @(negedge clk);
  endtask

  task automatic run_len(input logic [1:0] s, output int n);
    n = 0;
    while (phase == s && n < 20000) begin
      if (s == 2'd2) chk("R11 integrating", integrating, 1);
      chk("R6 low_power", low_power, (s == 2'd3) ? 1 : 0);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 phase in reset", phase, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 phase idle", phase, 0);
    chk("R1 outputs low", {integrating, conv_done, low_power}, 0);
    pwr_on = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle w/o conv_en", phase, 0);
  endtask

  task automatic t_back_to_back();
    int n;
    int_cfg = 8'hFF; wait_en = 0;
    conv_en = 1;
    @(negedge clk);
    chk("R2 enter init next clock", phase, 1);
    run_len(2'd1, n);
    chk("R2 init length", n, D);
    chk("R2 then integrate", phase, 2);
    run_len(2'd2, n);
    chk("R3 integ 0xFF", n, D);
    chk("R4 done high", conv_done, 1);
    chk("R5 init follows integ", phase, 1);
    @(negedge clk);
    chk("R4 done one clock", conv_done, 0);
    int_cfg = 8'hFD;
    wait_phase(2'd2);
    wait_phase(2'd1);
    wait_phase(2'd2);
    run_len(2'd2, n);
    chk("R3 integ 0xFD", n, 3 * D);
    chk("R5 no wait", phase, 1);
  endtask

  task automatic t_long_integ();
    int n;
    int_cfg = 8'h00;
    wait_phase(2'd1);
    wait_phase(2'd2);
    run_len(2'd2, n);
    chk("R3 integ 0x00", n, 256 * D);
  endtask

  task automatic t_wait();
    int n;
    int_cfg = 8'hFF; wait_en = 1; wait_cfg = 8'hFE; long_wait = 0;
    wait_phase(2'd2);
    run_len(2'd2, n);
    chk("R6 wait follows integ", phase, 3);
    run_len(2'd3, n);
    chk("R6 wait len 0xFE", n, 2 * D);
    chk("R6 init after wait", phase, 1);
    long_wait = 1; wait_cfg = 8'hFF;
    wait_phase(2'd2);
    run_len(2'd2, n);
    chk("R7 integ unchanged", n, D);
    run_len(2'd3, n);
    chk("R7 long wait 0xFF", n, 12 * D);
    wait_cfg = 8'hFE;
    wait_phase(2'd3);
    run_len(2'd3, n);
    chk("R7 long wait 0xFE", n, 24 * D);
    long_wait = 0; wait_en = 0;
  endtask

  task automatic t_sample();
    int n;
    int_cfg = 8'hFC;
    wait_phase(2'd1);
    wait_phase(2'd2);
    int_cfg = 8'hFE;
    run_len(2'd2, n);
    chk("R8 mid write ignored", n, 4 * D);
    wait_phase(2'd2);
    run_len(2'd2, n);
    chk("R8 applied next", n, 2 * D);
  endtask

  task automatic t_conv_stop();
    int n;
    int_cfg = 8'hFD;
    wait_phase(2'd1);
    wait_phase(2'd2);
    @(negedge clk);
    conv_en = 0;
    run_len(2'd2, n);
    chk("R10 integ completes", n, 3 * D - 1);
    chk("R10 done issued", conv_done, 1);
    chk("R10 idle after", phase, 0);
    repeat (20) @(negedge clk);
    chk("R10 stays idle", phase, 0);
  endtask

  task automatic t_power_off();
    int sum;
    wait_en = 1; wait_cfg = 8'hF0; int_cfg = 8'hFE; conv_en = 1;
    wait_phase(2'd3);
    repeat (3) @(negedge clk);
    pwr_on = 0;
    @(negedge clk);
    chk("R9 idle from wait", phase, 0);
    chk("R9 low_power off", low_power, 0);
    pwr_on = 1;
    wait_phase(2'd2);
    @(negedge clk);
    pwr_on = 0;
    sum = 0;
    @(negedge clk);
    chk("R9 idle from integ", phase, 0);
    repeat (2 * D) begin
      sum += conv_done;
      @(negedge clk);
    end
    chk("R9 no done", sum, 0);
    pwr_on = 1;
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_long_integ();
    t_wait();
    t_sample();
    t_conv_stop();
    t_power_off();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule